// File: doc/BRIEF.md
# Windowed Register File

This block is an integer register file that presents 32 architectural registers to an execution pipeline while keeping a larger physical pool behind them. The pool is cut into overlapping windows. A window pointer picks the set the program currently sees. A procedure call issues a save command and a return issues a restore command. After a save, the registers the caller used to hand over arguments appear in the callee as its incoming registers, and no data is copied.

The file has two combinational read ports and one write port. Each port is addressed by a 5-bit architectural number, and the block turns that number into a physical index. Register 0 is hard zero. Registers 1 to 7 are global and are the same in every window. Registers 8 to 15 are the outgoing argument registers. Registers 16 to 23 are the private locals. Registers 24 to 31 are the incoming arguments, which are the previous window's outgoing registers. A count of outstanding saves keeps the pointer from reaching a window that is still in use, and the block reports a rejected save or restore with a one-cycle flag.

Top module: `regwin_file`

## Requirements
- R1: Architectural register 0 reads as zero on both read ports at all times.
- R2: A write to architectural register 0 is discarded and leaves every other register unchanged.
- R3: Registers 1 to 7 hold the same values whichever window is current.
- R4: Registers 8 to 23 written in one window keep their values across a save and the matching restore back to that window.
- R5: After an accepted save, registers 24 to 31 read the values that registers 8 to 15 held before it. After an accepted restore, registers 8 to 15 read the values that registers 24 to 31 held before it.
- R6: After reset the window pointer is 0 and both flags are low. An accepted save adds 1 to the pointer and an accepted restore subtracts 1, modulo the window count. The new pointer is visible in the cycle after the command.
- R7: A save issued while NWIN-2 saves are outstanding is rejected. The overflow flag is high for exactly the next cycle and the pointer does not move.
- R8: A restore issued with no save outstanding is rejected. The underflow flag is high for exactly the next cycle and the pointer does not move.
- R9: If save and restore are requested in the same cycle, both are ignored: the pointer does not move and neither flag rises.
- R10: Reading a register in the same cycle it is written returns the old value. The new value is readable after the clock edge.
- R11: A write issued in the same cycle as a save goes to the window that was current before the save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| rd_a_idx | input | 5 | Architectural number for read port A |
| rd_a_data | output | XLEN | Read port A data, combinational |
| rd_b_idx | input | 5 | Architectural number for read port B |
| rd_b_data | output | XLEN | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural number for the write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Save command (move to a new window) |
| restore_req | input | 1 | Restore command (return to the previous window) |
| cwp | output | $clog2(NWIN) | Current window pointer |
| ovf_flag | output | 1 | One-cycle pulse on a rejected save |
| unf_flag | output | 1 | One-cycle pulse on a rejected restore |

## Verification
The bench builds the block with NWIN=4 and XLEN=32, which gives a 72-entry physical pool. With this size every window depth from reset to the overflow limit and back to the underflow limit can be visited. At each step all 32 architectural numbers are written and read on both ports. Register contents are tagged with the window and the register number, so a fault in the window overlap, including the case where window 0's incoming registers wrap into the last window, shows up as a wrong tag.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int ARCH_W   = 5;
  localparam int GLB_CNT  = 8;
  localparam int WIN_SPAN = 16;

  typedef enum logic [2:0] {
    RC_ZERO,
    RC_GLOBAL,
    RC_OUT,
    RC_LOCAL,
    RC_IN
  } reg_class_e;

  function automatic reg_class_e classify(input logic [ARCH_W-1:0] a);
    reg_class_e c;
    case (a[4:3])
      2'd0:    c = (a[2:0] == 3'd0) ? RC_ZERO : RC_GLOBAL;
      2'd1:    c = RC_OUT;
      2'd2:    c = RC_LOCAL;
      default: c = RC_IN;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/regwin_map.sv
module regwin_map
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WPW  = $clog2(NWIN),
  parameter int PW   = $clog2(GLB_CNT + WIN_SPAN * NWIN)
) (
  input  logic [ARCH_W-1:0] arch,
  input  logic [WPW-1:0]    cwp,
  output logic [PW-1:0]     phys
);

  logic [WPW-1:0] prv;
  logic [PW-1:0]  cur_base;
  logic [PW-1:0]  prv_base;

  always_comb begin
    prv      = (cwp == '0) ? WPW'(NWIN - 1) : cwp - 1'b1;
    cur_base = PW'(GLB_CNT) + PW'(cwp) * PW'(WIN_SPAN);
    prv_base = PW'(GLB_CNT) + PW'(prv) * PW'(WIN_SPAN);
    case (classify(arch))
      RC_ZERO:   phys = '0;
      RC_GLOBAL: phys = PW'(arch[2:0]);
      RC_OUT:    phys = cur_base + PW'(arch[2:0]);
      RC_LOCAL:  phys = cur_base + PW'(8) + PW'(arch[2:0]);
      default:   phys = prv_base + PW'(arch[2:0]);
    endcase
  end

endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
  parameter int NWIN = 8,
  parameter int WPW  = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           save_req,
  input  logic           restore_req,
  output logic [WPW-1:0] cwp,
  output logic           ovf_flag,
  output logic           unf_flag
);

  localparam int DW = $clog2(NWIN);
  localparam logic [DW-1:0] DEP_MAX = DW'(NWIN - 2);

  logic [WPW-1:0] cwp_q, cwp_n;
  logic [DW-1:0]  dep_q, dep_n;
  logic           ovf_q, ovf_n, unf_q, unf_n;
  logic           st_en;

  always_comb begin
    cwp_n = cwp_q;
    dep_n = dep_q;
    ovf_n = 1'b0;
    unf_n = 1'b0;
    if (save_req && !restore_req) begin
      if (dep_q == DEP_MAX) begin
        ovf_n = 1'b1;
      end else begin
        cwp_n = (cwp_q == WPW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
        dep_n = dep_q + 1'b1;
      end
    end else if (restore_req && !save_req) begin
      if (dep_q == '0) begin
        unf_n = 1'b1;
      end else begin
        cwp_n = (cwp_q == '0) ? WPW'(NWIN - 1) : cwp_q - 1'b1;
        dep_n = dep_q - 1'b1;
      end
    end
  end

  assign st_en = save_req | restore_req | ovf_q | unf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      dep_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (st_en) begin
      cwp_q <= cwp_n;
      dep_q <= dep_n;
      ovf_q <= ovf_n;
      unf_q <= unf_n;
    end
  end

  assign cwp      = cwp_q;
  assign ovf_flag = ovf_q;
  assign unf_flag = unf_q;

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    dep_q <= DEP_MAX); // R7
  AST_OVF_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $stable(cwp_q)); // R7
  AST_UNF_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |-> $stable(cwp_q)); // R8
  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !restore_req) |=>
      (ovf_q || cwp_q == (($past(cwp_q) == WPW'(NWIN - 1)) ? '0 : $past(cwp_q) + 1'b1))); // R6
  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req) |=>
      (unf_q || cwp_q == (($past(cwp_q) == '0) ? WPW'(NWIN - 1) : $past(cwp_q) - 1'b1))); // R6
  AST_BOTH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |=> ($stable(cwp_q) && !ovf_q && !unf_q)); // R9

endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int XLEN   = 64,
  parameter int PDEPTH = 136,
  parameter int PW     = $clog2(PDEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [PW-1:0]   raddr_a,
  input  logic [PW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);

  logic [XLEN-1:0] mem [PDEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int XLEN = 64,
  parameter int WPW  = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  output logic [WPW-1:0]  cwp,
  output logic            ovf_flag,
  output logic            unf_flag
);

  localparam int PDEPTH = GLB_CNT + WIN_SPAN * NWIN;
  localparam int PW     = $clog2(PDEPTH);

  logic [PW-1:0]   ph_a, ph_b, ph_w;
  logic [XLEN-1:0] raw_a, raw_b;
  logic            wr_go;

  regwin_ptr #(.NWIN(NWIN), .WPW(WPW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .cwp(cwp), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  regwin_map #(.NWIN(NWIN), .WPW(WPW), .PW(PW)) u_map_a (
    .arch(rd_a_idx), .cwp(cwp), .phys(ph_a));
  regwin_map #(.NWIN(NWIN), .WPW(WPW), .PW(PW)) u_map_b (
    .arch(rd_b_idx), .cwp(cwp), .phys(ph_b));
  regwin_map #(.NWIN(NWIN), .WPW(WPW), .PW(PW)) u_map_w (
    .arch(wr_idx), .cwp(cwp), .phys(ph_w));

  assign wr_go = wr_en && (wr_idx != '0);

  regwin_store #(.XLEN(XLEN), .PDEPTH(PDEPTH), .PW(PW)) u_store (
    .clk(clk), .we(wr_go), .waddr(ph_w), .wdata(wr_data),
    .raddr_a(ph_a), .raddr_b(ph_b), .rdata_a(raw_a), .rdata_b(raw_b)
  );

  assign rd_a_data = (rd_a_idx == '0) ? '0 : raw_a;
  assign rd_b_data = (rd_b_idx == '0) ? '0 : raw_b;

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_data == '0)); // R1
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == '0) |-> (rd_b_data == '0)); // R1
  AST_NO_PHYS0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> (ph_w != '0)); // R2
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_flag && unf_flag)); // R7

endmodule

// File: tb/tb_regwin_file.sv
module tb_regwin_file;

  localparam int NW  = 4;
  localparam int XL  = 32;
  localparam int WP  = $clog2(NW);
  localparam int PD  = 8 + 16 * NW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [4:0]    rd_a_idx, rd_b_idx, wr_idx;
  logic [XL-1:0] rd_a_data, rd_b_data, wr_data;
  logic          wr_en, save_req, restore_req;
  logic [WP-1:0] cwp;
  logic          ovf_flag, unf_flag;

  int n_chk = 0;
  int n_bad = 0;
  int seq   = 0;
  int ecwp  = 0;
  int edep  = 0;
  bit done  = 1'b0;
  logic [XL-1:0] pm [PD];
  logic [XL-1:0] keep [8];

  always #10 clk = ~clk;

  regwin_file #(.NWIN(NW), .XLEN(XL)) dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .cwp(cwp), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  function automatic int bmap(int r, int w);
    if (r == 0) return 0;
    if (r < 8)  return r;
    if (r < 16) return 8 + 16 * w + (r - 8);
    if (r < 24) return 16 + 16 * w + (r - 16);
    return 8 + 16 * ((w + NW - 1) % NW) + (r - 24);
  endfunction

  function automatic string rtag(int r);
    if (r == 0) return "R1";
    if (r < 8)  return "R3";
    if (r < 24) return "R4";
    return "R5";
  endfunction

  task automatic chk(bit ok, string req, logic [XL-1:0] act, logic [XL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [XL-1:0] model(int r);
    if (r == 0) return '0;
    return pm[bmap(r, ecwp)];
  endfunction

  task automatic wr(int r, logic [XL-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(r); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (r != 0) pm[bmap(r, ecwp)] = v;
  endtask

  task automatic fill();
    for (int r = 1; r < 32; r++) begin
      seq++;
      wr(r, {8'(ecwp), 8'(r), 16'(seq)});
    end
  endtask

  task automatic readall();
    for (int r = 0; r < 32; r++) begin
      rd_a_idx = 5'(r);
      rd_b_idx = 5'(31 - r);
      #1;
      chk(rd_a_data === model(r), rtag(r), rd_a_data, model(r));
      chk(rd_b_data === model(31 - r), rtag(31 - r), rd_b_data, model(31 - r));
    end
  endtask

  task automatic cmd(bit s, bit r);
    bit eo, eu;
    eo = 1'b0; eu = 1'b0;
    @(negedge clk);
    save_req = s; restore_req = r;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0;
    if (s && !r) begin
      if (edep == NW - 2) eo = 1'b1;
      else begin ecwp = (ecwp + 1) % NW; edep++; end
    end else if (r && !s) begin
      if (edep == 0) eu = 1'b1;
      else begin ecwp = (ecwp + NW - 1) % NW; edep--; end
    end
    chk(cwp == WP'(ecwp), (s && r) ? "R9" : "R6", XL'(cwp), XL'(ecwp));
    chk(ovf_flag == eo, "R7", XL'(ovf_flag), XL'(eo));
    chk(unf_flag == eu, "R8", XL'(unf_flag), XL'(eu));
    if (eo || eu) begin
      @(negedge clk);
      chk(!ovf_flag && !unf_flag, eo ? "R7" : "R8", XL'({ovf_flag, unf_flag}), '0);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    save_req = 1'b0; restore_req = 1'b0; rd_a_idx = '0; rd_b_idx = '0;
    for (int i = 0; i < PD; i++) pm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cwp == '0, "R6", XL'(cwp), '0);
    chk(!ovf_flag && !unf_flag, "R6", XL'({ovf_flag, unf_flag}), '0);

    fill();
    readall();

    // R2: write to register 0 discarded
    wr(0, 32'hDEAD_BEEF);
    readall();

    // Save down to the limit, checking the overlap (R5) at every step
    for (int k = 0; k < NW - 2; k++) begin
      for (int r = 8; r < 16; r++) keep[r - 8] = model(r);
      cmd(1'b1, 1'b0);
      for (int r = 24; r < 32; r++) begin
        rd_a_idx = 5'(r); #1;
        chk(rd_a_data === keep[r - 24], "R5", rd_a_data, keep[r - 24]);
      end
      readall();
      fill();
      readall();
    end

    // R7: one save too many
    cmd(1'b1, 1'b0);
    readall();
    // R9: both commands together
    cmd(1'b1, 1'b1);
    readall();

    // Restore back to the start, checking R5 and R4
    for (int k = 0; k < NW - 2; k++) begin
      for (int r = 24; r < 32; r++) keep[r - 24] = model(r);
      cmd(1'b0, 1'b1);
      for (int r = 8; r < 16; r++) begin
        rd_b_idx = 5'(r); #1;
        chk(rd_b_data === keep[r - 8], "R5", rd_b_data, keep[r - 8]);
      end
      readall();
    end

    // R8: restore with nothing saved
    cmd(1'b0, 1'b1);
    cmd(1'b1, 1'b1);
    readall();

    // R10: read during write returns old value
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'h1234_5678; rd_a_idx = 5'd5;
    #1;
    chk(rd_a_data === model(5), "R10", rd_a_data, model(5));
    @(negedge clk);
    wr_en = 1'b0;
    pm[5] = 32'h1234_5678;
    #1;
    chk(rd_a_data === 32'h1234_5678, "R10", rd_a_data, 32'h1234_5678);

    // R11: write in the same cycle as save lands in the old window
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'hCAFE_0009; save_req = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; save_req = 1'b0;
    pm[bmap(9, ecwp)] = 32'hCAFE_0009;
    ecwp = (ecwp + 1) % NW; edep++;
    chk(cwp == WP'(ecwp), "R11", XL'(cwp), XL'(ecwp));
    rd_a_idx = 5'd25; #1;
    chk(rd_a_data === 32'hCAFE_0009, "R11", rd_a_data, 32'hCAFE_0009);
    readall();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule